// File: doc/BRIEF.md
# USB Host Command and Status Registers

This block keeps the run control bit and the interrupt and status word of a USB 2.0 host controller. Both are reached through a plain 32-bit register bus: an address, a write strobe and write data go in, and read data comes back combinationally for whatever address is presented. The run control bit goes out to the schedule engine. When software clears it, the engine finishes its current work and returns a one-cycle stop-done pulse. Only that pulse moves the controller into the halted state.

Four sticky event flags collect hardware events. These are the asynchronous-advance doorbell, a host system error, a wrap of the frame list index, and a rising change bit on any root port. Software clears a flag by writing a one to its position. A single level interrupt output is raised while any flag is set and its enable input is high. Three further status bits show live schedule state from the engine and are not stored.

Top module: `usbhc_cmd_status`

## Requirements
- R1: After reset the command word reads 0x0000_0000, the status word reads 0x0000_1000 (only the halted bit, bit 12, is set, with the live inputs low), and `irq` is low.
- R2: The command word is at byte offset 0x10, and its bit 0 is the run bit. It is readable and writable and drives `run_stop`. A write of 1 makes the halted bit (status bit 12) read 0 in the same cycle that the run bit first reads 1.
- R3: After the run bit is written to 0, the halted bit stays 0 for as many cycles as it takes until `stop_done` pulses. It reads 1 from the cycle after that pulse.
- R4: A `stop_done` pulse that arrives while the run bit is 1 is ignored, and the halted bit stays 0.
- R5: The status word is at byte offset 0x14. Its sticky bits are bit 5 (async advance), bit 4 (system error), bit 3 (frame wrap) and bit 2 (port change). Writing 1 to one of these positions clears that bit, and writing 0 leaves it unchanged.
- R6: When a hardware set and a software clear hit the same sticky bit in the same cycle, the bit ends up set.
- R7: A one-cycle pulse on `async_adv_evt` sets bit 5, and a pulse on `sys_err_evt` sets bit 4.
- R8: Bit 3 is set when `frame_idx` goes from its all-ones value to zero. A change to zero from any other value does not set it.
- R9: Bit 2 is set when any bit of `port_chg` rises from 0 to 1. A bit that stays high, or a bit that falls, does not set it again after it has been cleared.
- R10: Status bits 15, 14 and 13 show the current levels of `async_sched_on`, `periodic_sched_on` and `async_reclaim`. Writes do not affect them.
- R11: Status bits 31:16 and 11:6 always read 0, and any offset other than 0x10 or 0x14 reads 0.
- R12: `irq` is high exactly while some sticky bit is set and its enable is high. The mapping is `irq_en[0]` to bit 2, `irq_en[1]` to bit 3, `irq_en[2]` to bit 4 and `irq_en[3]` to bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| run_stop | output | 1 | Run bit sent to the schedule engine |
| stop_done | input | 1 | One-cycle pulse from the engine when it has stopped |
| async_adv_evt | input | 1 | Pulse for the async advance doorbell |
| sys_err_evt | input | 1 | Pulse for a host system error |
| frame_idx | input | FIDX_W | Current frame list index |
| port_chg | input | NPORTS | Change bits, one per port |
| async_sched_on | input | 1 | Live state of the async schedule |
| periodic_sched_on | input | 1 | Live state of the periodic schedule |
| async_reclaim | input | 1 | Live reclamation flag |
| irq_en | input | 4 | Enables for status bits 2 to 5 |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are collisions: a hardware event and a write-one-to-clear landing on the same flag in the same cycle, and a stop-done pulse arriving while the run bit is still set. A vector table drives the event pulses and the status write on the same clock edge and carries the expected flag state forward from one row to the next. Directed tests then hold the controller in the stopping state for several cycles before pulsing stop-done, hold a port change bit high across a clear, and send the frame index through a wrap and through a change to zero that is not a wrap.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 32;
  localparam logic [ADDR_W-1:0] CMD_OFS = 8'h10;
  localparam logic [ADDR_W-1:0] STS_OFS = 8'h14;
  localparam int B_RUN   = 0;
  localparam int B_PORT  = 2;
  localparam int B_WRAP  = 3;
  localparam int B_SERR  = 4;
  localparam int B_ADV   = 5;
  localparam int B_HALT  = 12;
  localparam int B_RECL  = 13;
  localparam int B_PSCH  = 14;
  localparam int B_ASCH  = 15;
  localparam int N_FLAG  = 4;
  localparam int FLAG_LO = B_PORT;
endpackage

// File: rtl/usbhc_rst_sync.sv
module usbhc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/usbhc_runstop.sv
module usbhc_runstop (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_bit,
  input  logic stop_done,
  output logic run_q,
  output logic halt_q
);
  logic run_d, halt_d;

  always_comb begin
    run_d = run_q;
    if (cmd_wr) run_d = cmd_bit;
  end

  always_comb begin
    halt_d = halt_q;
    if (run_d)                     halt_d = 1'b0;
    else if (stop_done && !run_q)  halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (cmd_wr) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b1;
    else        halt_q <= halt_d;
  end

  // R2
  a_r2_run_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !halt_q);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bit) |=> (run_q && !halt_q));
  // R3
  a_r3_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !stop_done) |=> !halt_q);
  // R4
  a_r4_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stop_done) |=> !halt_q);
endmodule

// File: rtl/usbhc_edge_det.sv
module usbhc_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic         rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  assign rise = |(sig & ~prev_q);

  // R9
  a_r9_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (sig != '0));
endmodule

// File: rtl/usbhc_wrap_det.sv
module usbhc_wrap_det #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] idx,
  output logic         wrap
);
  localparam logic [W-1:0] IDX_MAX = '1;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= idx;
  end

  assign wrap = (prev_q == IDX_MAX) && (idx == '0);

  // R8
  a_r8_wrap_lands_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (idx == '0));
endmodule

// File: rtl/usbhc_sticky.sv
module usbhc_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic d, en;

  always_comb begin
    en = set | clr;
    d  = set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

  // R6
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R5
  a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/usbhc_cmd_status.sv
module usbhc_cmd_status
  import usbhc_pkg::*;
#(
  parameter int FIDX_W = 11,
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              run_stop,
  input  logic              stop_done,
  input  logic              async_adv_evt,
  input  logic              sys_err_evt,
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic [NPORTS-1:0] port_chg,
  input  logic              async_sched_on,
  input  logic              periodic_sched_on,
  input  logic              async_reclaim,
  input  logic [3:0]        irq_en,
  output logic              irq
);
  logic rst_n;
  logic cmd_sel, sts_sel, cmd_wr, sts_wr;
  logic run_q, halt_q;
  logic wrap_evt, port_evt;
  logic [N_FLAG-1:0] flag_set, flag_clr, flag_q;
  logic [REG_W-1:0] cmd_word, sts_word;

  usbhc_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  always_comb begin
    cmd_sel = (reg_addr == CMD_OFS);
    sts_sel = (reg_addr == STS_OFS);
    cmd_wr  = reg_wr && cmd_sel;
    sts_wr  = reg_wr && sts_sel;
  end

  usbhc_runstop u_rs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bit(reg_wdata[B_RUN]),
    .stop_done(stop_done), .run_q(run_q), .halt_q(halt_q)
  );

  usbhc_wrap_det #(.W(FIDX_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .idx(frame_idx), .wrap(wrap_evt)
  );

  usbhc_edge_det #(.W(NPORTS)) u_port (
    .clk(clk), .rst_n(rst_n), .sig(port_chg), .rise(port_evt)
  );

  always_comb begin
    flag_set[B_PORT-FLAG_LO] = port_evt;
    flag_set[B_WRAP-FLAG_LO] = wrap_evt;
    flag_set[B_SERR-FLAG_LO] = sys_err_evt;
    flag_set[B_ADV-FLAG_LO]  = async_adv_evt;
  end

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    assign flag_clr[i] = sts_wr && reg_wdata[FLAG_LO+i];
    usbhc_sticky u_bit (
      .clk(clk), .rst_n(rst_n), .set(flag_set[i]), .clr(flag_clr[i]), .q(flag_q[i])
    );
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[B_RUN] = run_q;
    sts_word = '0;
    sts_word[FLAG_LO +: N_FLAG] = flag_q;
    sts_word[B_HALT] = halt_q;
    sts_word[B_RECL] = async_reclaim;
    sts_word[B_PSCH] = periodic_sched_on;
    sts_word[B_ASCH] = async_sched_on;
  end

  always_comb begin
    if (cmd_sel)      reg_rdata = cmd_word;
    else if (sts_sel) reg_rdata = sts_word;
    else              reg_rdata = '0;
  end

  assign run_stop = run_q;
  assign irq      = |(flag_q & irq_en);

  // R12
  a_r12_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq);
  // R11
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:16] == '0) && (reg_rdata[11:6] == '0));
endmodule

// File: tb/usbhc_cmd_status_tb.sv
`timescale 1ns/1ps
module usbhc_cmd_status_tb;
  localparam int FIDX_W = 11;
  localparam int NPORTS = 4;
  localparam logic [FIDX_W-1:0] FMAX = '1;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic run_stop, irq;
  logic stop_done = 1'b0, async_adv_evt = 1'b0, sys_err_evt = 1'b0;
  logic [FIDX_W-1:0] frame_idx = '0;
  logic [NPORTS-1:0] port_chg = '0;
  logic async_sched_on = 1'b0, periodic_sched_on = 1'b0, async_reclaim = 1'b0;
  logic [3:0] irq_en = 4'h0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbhc_cmd_status #(.FIDX_W(FIDX_W), .NPORTS(NPORTS)) u_dut (
    .clk(clk), .arst_n(arst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_stop(run_stop),
    .stop_done(stop_done), .async_adv_evt(async_adv_evt), .sys_err_evt(sys_err_evt),
    .frame_idx(frame_idx), .port_chg(port_chg), .async_sched_on(async_sched_on),
    .periodic_sched_on(periodic_sched_on), .async_reclaim(async_reclaim),
    .irq_en(irq_en), .irq(irq)
  );

  // {adv, serr, wr, clr[5:2], exp[5:2]}
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'b0000, 4'b1000},
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b1100},
    {1'b0, 1'b0, 1'b1, 4'b0100, 4'b1000},
    {1'b0, 1'b0, 1'b1, 4'b0000, 4'b1000},
    {1'b1, 1'b0, 1'b1, 4'b1000, 4'b1000},
    {1'b0, 1'b1, 1'b1, 4'b1000, 4'b0100},
    {1'b0, 1'b0, 1'b1, 4'b1111, 4'b0000},
    {1'b1, 1'b1, 1'b1, 4'b1100, 4'b1100},
    {1'b0, 1'b0, 1'b1, 4'b1100, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    reg_wr = 1'b0;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic sts_bit(input int b, input string req, input logic exp);
    logic [31:0] v;
    rd(8'h14, v);
    check(req, {31'b0, v[b]}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    rd(8'h10, v); check("R1 cmd", v, 32'h0);
    rd(8'h14, v); check("R1 sts", v, 32'h0000_1000);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      async_adv_evt = VEC[i][10];
      sys_err_evt   = VEC[i][9];
      reg_wr        = VEC[i][8];
      reg_addr      = 8'h14;
      reg_wdata     = {26'b0, VEC[i][7:4], 2'b00};
      tick();
      async_adv_evt = 1'b0;
      sys_err_evt   = 1'b0;
      reg_wr        = 1'b0;
      reg_wdata     = '0;
      rd(8'h14, v);
      check($sformatf("R5/R6/R7 vector %0d", i), {28'b0, v[5:2]}, {28'b0, VEC[i][3:0]});
    end

    // R2 start
    wr(8'h10, 32'h1);
    rd(8'h10, v); check("R2 run bit", v, 32'h1);
    check("R2 run_stop", {31'b0, run_stop}, 32'h1);
    sts_bit(12, "R2 halted cleared", 1'b0);

    // R4 stop_done while running
    stop_done = 1'b1; tick(); stop_done = 1'b0;
    sts_bit(12, "R4 done ignored", 1'b0);

    // R3 stop handshake
    wr(8'h10, 32'h0);
    rd(8'h10, v); check("R3 run cleared", v, 32'h0);
    sts_bit(12, "R3 not yet halted", 1'b0);
    repeat (5) tick();
    sts_bit(12, "R3 still waiting", 1'b0);
    stop_done = 1'b1; tick(); stop_done = 1'b0;
    sts_bit(12, "R3 halted after done", 1'b1);

    // R10 live bits
    async_sched_on = 1'b1; periodic_sched_on = 1'b0; async_reclaim = 1'b1;
    rd(8'h14, v); check("R10 live 101", {29'b0, v[15:13]}, 32'h5);
    async_sched_on = 1'b0; periodic_sched_on = 1'b1; async_reclaim = 1'b0;
    rd(8'h14, v); check("R10 live 010", {29'b0, v[15:13]}, 32'h2);

    // R11 reserved and unmapped
    async_sched_on = 1'b1; async_reclaim = 1'b1;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R11 reserved", v & 32'hFFFF_0FC0, 32'h0);
    check("R10 write no effect", {29'b0, v[15:13]}, 32'h7);
    rd(8'h18, v); check("R11 unmapped", v, 32'h0);
    async_sched_on = 1'b0; periodic_sched_on = 1'b0; async_reclaim = 1'b0;

    // R8 frame wrap
    frame_idx = FMAX - 1; tick();
    frame_idx = FMAX; tick();
    sts_bit(3, "R8 no early set", 1'b0);
    frame_idx = '0; tick();
    sts_bit(3, "R8 wrap sets", 1'b1);
    wr(8'h14, 32'h8);
    frame_idx = 11'd5; tick();
    frame_idx = '0; tick();
    sts_bit(3, "R8 non-wrap zero", 1'b0);

    // R9 port change edges
    port_chg = 4'b0010; tick();
    sts_bit(2, "R9 rise sets", 1'b1);
    wr(8'h14, 32'h4);
    tick();
    sts_bit(2, "R9 held level no reset", 1'b0);
    port_chg = 4'b0000; tick();
    sts_bit(2, "R9 fall ignored", 1'b0);
    port_chg = 4'b1000; tick();
    sts_bit(2, "R9 other port rise", 1'b1);

    // R12 interrupt enables (bit 2 set only)
    irq_en = 4'b0000; #1;
    check("R12 disabled", {31'b0, irq}, 32'h0);
    irq_en = 4'b1110; #1;
    check("R12 other enables", {31'b0, irq}, 32'h0);
    irq_en = 4'b0001; #1;
    check("R12 enabled", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h4);
    check("R12 drops on clear", {31'b0, irq}, 32'h0);
    async_adv_evt = 1'b1; irq_en = 4'b1000; tick(); async_adv_evt = 1'b0; #1;
    check("R12 bit5 mapping", {31'b0, irq}, 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule